// File: doc/BRIEF.md
# Trusted-Module Host Register Block

This block is the device side of a trusted-module host interface on a byte-wide memory-mapped bus. The host claims the device by writing the access register. It asks for the ready state through the status register and pushes a command one byte at a time into a data port. It then starts execution with a go write and pulls the response back through the same data port. A 16-bit burst count tells the host how many bytes it may move before it polls again.

The block has one locality. Command execution is a stub: once a timer of `EXEC_CYCLES` clock cycles runs out, the stub offers a canned response of `RSP_LEN` bytes. The response opens with a fixed ten-byte header (tag 0x00C4, big-endian total length, zero return code). The remaining response bytes repeat the command bytes held at the same index. Any offset the block does not decode reads as 0xFF, so interrupt, identity and legacy-alias space looks absent.

Bus timing: a write takes effect at the clock edge where `bus_wr` is high. A read samples the register state at the edge where `bus_rd` is high. The byte appears on `bus_rdata` after that edge and stays there until the next read.

Top module: `tmod_regblock`

## Requirements
- R1: After reset, the access register (offset 0x00) reads 0x81. Once the locality is claimed and before any other write, status (0x18) reads 0x80 and the burst count reads 0.
- R2: An access write sets the active bit (bit 5) if bit 1 (request use) or bit 3 (seize) is set. The register then reads 0xA1. An access write with bit 5 set gives the locality up, and the register returns to 0x81; giving up takes priority over requesting.
- R3: While the locality is not active, status, burst-count and data-port reads all return 0xFF, and writes to status and to the data port have no effect.
- R4: Every offset other than 0x00, 0x18, 0x19, 0x1A and 0x24 reads 0xFF.
- R5: Writing status bit 6 (ready) enters the ready state from any state. Status then reads 0xC0 (bit 7 valid, bit 6 ready) and the burst count equals `DEPTH`. Any stored command or pending response is dropped.
- R6: Data-port (0x24) writes in the ready or receiving state store command bytes. After the first byte, status reads 0x88 (bit 3 expect) until the byte count reaches the length. That length is the big-endian 32-bit field in command bytes 2 to 5, and at least 6 bytes are needed. Status then reads 0x80, and further bytes are ignored.
- R7: While a command is being written, the burst count is `DEPTH` minus the bytes stored, little-endian at 0x19 (low) and 0x1A (high). Once the command is complete, or `DEPTH` bytes are stored, it is 0, and writes to a full buffer are dropped.
- R8: A go write (status bit 5) starts execution only when the command is complete. Otherwise it is ignored.
- R9: After an accepted go, data-available (status bit 4) reads 0 for `EXEC_CYCLES` cycles. From then on status reads 0x90 and the burst count equals `RSP_LEN`.
- R10: Each data-port read returns the next response byte and lowers the burst count by one. After `RSP_LEN` bytes, status reads 0x80, the burst count reads 0, and data-port reads return 0xFF.
- R11: A retry write (status bit 1) while a response is held rewinds the response to its first byte.
- R12: A ready write while a response is held discards it. Status reads 0xC0 and data-port reads return 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per byte; a data-port read pops |
| bus_rdata | output | 8 | Registered read data, valid the cycle after `bus_rd` |

## Verification
A wrong byte count or captured length shows up in the burst count and in the expect bit on the very next read after the faulty write. A wrong execution timer moves the cycle at which data-available first reads 1, so the bench reads status exactly one cycle before and at the expected boundary. A response pointer that drifts, fails to rewind or fails to clear shows in the next data-port byte or burst-count read. Gating errors tied to the claim show as non-0xFF reads, or as state changes visible once the locality is claimed again.

// File: rtl/tmod_pkg.sv
package tmod_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READY,
    ST_RECV,
    ST_EXEC,
    ST_RESP
  } tm_state_e;

  // decoded byte offsets
  localparam int OFS_ACCESS   = 'h00;
  localparam int OFS_STATUS   = 'h18;
  localparam int OFS_BURST_LO = 'h19;
  localparam int OFS_BURST_HI = 'h1A;
  localparam int OFS_FIFO     = 'h24;

  // access register bits
  localparam int ACC_REQ     = 1;
  localparam int ACC_SEIZE   = 3;
  localparam int ACC_RELINQ  = 5;

  // status register bits
  localparam int STS_READY = 6;
  localparam int STS_GO    = 5;
  localparam int STS_RETRY = 1;

  localparam int HDR_BYTES = 10;

  // canned response byte at position idx
  function automatic logic [7:0] rsp_byte(input logic [15:0] idx,
                                          input logic [15:0] len,
                                          input logic [7:0]  echo);
    logic [7:0] b;
    if (idx == 16'd1)                b = 8'hC4;
    else if (idx == 16'd4)           b = len[15:8];
    else if (idx == 16'd5)           b = len[7:0];
    else if (idx < 16'(HDR_BYTES))   b = 8'h00;
    else                             b = echo;
    return b;
  endfunction

endpackage

// File: rtl/tmod_cmd_buf.sv
module tmod_cmd_buf #(
  parameter int DEPTH = 1024,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [7:0]       wdata,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data,
  output logic [CNT_W-1:0] cnt,
  output logic             complete
);

  logic [7:0]  mem [DEPTH];
  logic [31:0] len_q;
  logic        accept;

  assign complete = (cnt >= CNT_W'(6)) && (32'(cnt) >= len_q);
  assign accept   = wr_en && !complete && (cnt < CNT_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (accept) mem[cnt[IDX_W-1:0]] <= wdata;
  end

  assign rd_data = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt   <= '0;
      len_q <= '0;
    end else if (accept) begin
      cnt <= cnt + CNT_W'(1);
      if (cnt >= CNT_W'(2) && cnt <= CNT_W'(5)) len_q <= {len_q[23:0], wdata};
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(DEPTH)); // R7
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    clr |=> cnt == '0); // R5
  AST_DONE_FREEZES: assert property (@(posedge clk) disable iff (rst)
    complete && !clr |=> $stable(cnt)); // R6

endmodule

// File: rtl/tmod_exec_engine.sv
module tmod_exec_engine
  import tmod_pkg::*;
#(
  parameter int EXEC_CYCLES = 16,
  parameter int RSP_LEN     = 12,
  localparam int TW = $clog2(EXEC_CYCLES + 1)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        start,
  input  logic        retry,
  input  logic        pop,
  input  logic [7:0]  echo_byte,
  output logic        done,
  output logic [15:0] ptr,
  output logic [15:0] left,
  output logic [7:0]  rsp_data
);

  logic          busy_q;
  logic [TW-1:0] timer_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      busy_q  <= 1'b0;
      timer_q <= '0;
    end else if (start) begin
      busy_q  <= 1'b1;
      timer_q <= TW'(EXEC_CYCLES - 1);
    end else if (busy_q) begin
      if (timer_q == '0) busy_q <= 1'b0;
      else               timer_q <= timer_q - TW'(1);
    end
  end

  assign done = busy_q && (timer_q == '0);

  always_ff @(posedge clk) begin
    if (rst || clr || start || retry) ptr <= '0;
    else if (pop && ptr < 16'(RSP_LEN)) ptr <= ptr + 16'd1;
  end

  assign left     = 16'(RSP_LEN) - ptr;
  assign rsp_data = rsp_byte(ptr, 16'(RSP_LEN), echo_byte);

  AST_PTR_BOUND: assert property (@(posedge clk) disable iff (rst)
    ptr <= 16'(RSP_LEN)); // R10
  AST_RETRY_REWINDS: assert property (@(posedge clk) disable iff (rst)
    retry |=> ptr == 16'd0); // R11
  AST_TIMER_QUIET: assert property (@(posedge clk) disable iff (rst)
    start |=> !done || (EXEC_CYCLES == 1)); // R9

endmodule

// File: rtl/tmod_regblock.sv
module tmod_regblock
  import tmod_pkg::*;
#(
  parameter int   ADDR_W      = 12,
  parameter int   DEPTH       = 1024,
  parameter int   RSP_LEN     = 12,
  parameter int   EXEC_CYCLES = 16,
  parameter logic NO_TOS      = 1'b1,
  localparam int  CNT_W = $clog2(DEPTH + 1),
  localparam int  IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata
);

  tm_state_e        state;
  logic             active_q;
  logic             hit_acc, hit_sts, hit_blo, hit_bhi, hit_fifo;
  logic             wr_sts, wr_fifo, rd_fifo;
  logic             rdy_cmd, go_ok, retry_cmd, pop;
  logic [CNT_W-1:0] cmd_cnt;
  logic             cmd_complete;
  logic [7:0]       echo_byte, rsp_data;
  logic             exec_done;
  logic [15:0]      rsp_ptr, rsp_left;
  logic             avail, expect_more;
  logic [15:0]      burst;
  logic [7:0]       status_b, access_b, rd_next;

  assign hit_acc  = bus_addr == ADDR_W'(OFS_ACCESS);
  assign hit_sts  = bus_addr == ADDR_W'(OFS_STATUS);
  assign hit_blo  = bus_addr == ADDR_W'(OFS_BURST_LO);
  assign hit_bhi  = bus_addr == ADDR_W'(OFS_BURST_HI);
  assign hit_fifo = bus_addr == ADDR_W'(OFS_FIFO);

  assign wr_sts  = bus_wr && hit_sts  && active_q;
  assign wr_fifo = bus_wr && hit_fifo && active_q;
  assign rd_fifo = bus_rd && hit_fifo && active_q;

  assign rdy_cmd   = wr_sts && bus_wdata[STS_READY];
  assign go_ok     = wr_sts && bus_wdata[STS_GO] && !bus_wdata[STS_READY]
                     && (state == ST_RECV) && cmd_complete;
  assign retry_cmd = wr_sts && bus_wdata[STS_RETRY] && !bus_wdata[STS_READY]
                     && (state == ST_RESP);

  // locality claim
  always_ff @(posedge clk) begin
    if (rst) active_q <= 1'b0;
    else if (bus_wr && hit_acc) begin
      if (bus_wdata[ACC_RELINQ]) active_q <= 1'b0;
      else if (bus_wdata[ACC_REQ] || bus_wdata[ACC_SEIZE]) active_q <= 1'b1;
    end
  end

  // command/response sequencing
  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else if (rdy_cmd) state <= ST_READY;
    else begin
      case (state)
        ST_READY: if (wr_fifo)   state <= ST_RECV;
        ST_RECV:  if (go_ok)     state <= ST_EXEC;
        ST_EXEC:  if (exec_done) state <= ST_RESP;
        default:  ;
      endcase
    end
  end

  tmod_cmd_buf #(.DEPTH(DEPTH)) u_buf (
    .clk      (clk),
    .rst      (rst),
    .clr      (rdy_cmd),
    .wr_en    (wr_fifo && (state == ST_READY || state == ST_RECV)),
    .wdata    (bus_wdata),
    .rd_idx   (rsp_ptr[IDX_W-1:0]),
    .rd_data  (echo_byte),
    .cnt      (cmd_cnt),
    .complete (cmd_complete)
  );

  tmod_exec_engine #(.EXEC_CYCLES(EXEC_CYCLES), .RSP_LEN(RSP_LEN)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .clr       (rdy_cmd),
    .start     (go_ok),
    .retry     (retry_cmd),
    .pop       (pop),
    .echo_byte (echo_byte),
    .done      (exec_done),
    .ptr       (rsp_ptr),
    .left      (rsp_left),
    .rsp_data  (rsp_data)
  );

  assign avail       = (state == ST_RESP) && (rsp_left != 16'd0);
  assign pop         = rd_fifo && avail;
  assign expect_more = (state == ST_RECV) && !cmd_complete;

  always_comb begin
    burst = 16'd0;
    if (state == ST_READY || expect_more) burst = 16'(DEPTH) - 16'(cmd_cnt);
    else if (state == ST_RESP)            burst = rsp_left;
  end

  assign status_b = {1'b1, state == ST_READY, 1'b0, avail, expect_more, 3'b000};
  assign access_b = {1'b1, 1'b0, active_q, 4'b0000, NO_TOS};

  always_comb begin
    rd_next = 8'hFF;
    if (hit_acc)          rd_next = access_b;
    else if (!active_q)   rd_next = 8'hFF;
    else if (hit_sts)     rd_next = status_b;
    else if (hit_blo)     rd_next = burst[7:0];
    else if (hit_bhi)     rd_next = burst[15:8];
    else if (hit_fifo)    rd_next = avail ? rsp_data : 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= 8'hFF;
    else if (bus_rd) bus_rdata <= rd_next;
  end

  AST_CLAIM_GRANT: assert property (@(posedge clk) disable iff (rst)
    bus_wr && hit_acc && !bus_wdata[ACC_RELINQ]
    && (bus_wdata[ACC_REQ] || bus_wdata[ACC_SEIZE]) |=> active_q); // R2
  AST_IDLE_NO_STORE: assert property (@(posedge clk) disable iff (rst)
    !active_q && bus_wr && hit_fifo |=> $stable(cmd_cnt)); // R3
  AST_GO_NEEDS_CMD: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXEC) && ($past(state) != ST_EXEC) |-> $past(cmd_complete)); // R8
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
    rdy_cmd |=> (state == ST_READY) && (rsp_ptr == 16'd0)); // R12

endmodule

// File: tb/tmod_regblock_tb.sv
`timescale 1ns/1ps
module tmod_regblock_tb;

  localparam int DEPTH = 1024;
  localparam int RSP_LEN = 12;
  localparam int EXEC_CYCLES = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [7:0] cmd [16];

  always #2.5 clk = ~clk;

  tmod_regblock #(.DEPTH(DEPTH), .RSP_LEN(RSP_LEN), .EXEC_CYCLES(EXEC_CYCLES)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
  );

  // all bus tasks start and end at a falling edge
  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic chk(input string req, input logic [11:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    checks++;
    if (v !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, a, v, exp);
    end
  endtask

  task automatic chk_burst(input string req, input logic [15:0] exp);
    chk(req, 12'h019, exp[7:0]);
    chk(req, 12'h01A, exp[15:8]);
  endtask

  task automatic load_cmd(input int n);
    for (int i = 0; i < n; i++) wr(12'h024, cmd[i]);
  endtask

  task automatic t_reset_and_idle;
    chk("R1", 12'h000, 8'h81);
    chk("R3", 12'h018, 8'hFF);
    chk("R3", 12'h024, 8'hFF);
    chk("R3", 12'h019, 8'hFF);
    wr(12'h018, 8'h40);        // ignored: not claimed
    chk("R4", 12'hF00, 8'hFF);
    chk("R4", 12'h008, 8'hFF);
  endtask

  task automatic t_claim;
    wr(12'h000, 8'h02);
    chk("R2", 12'h000, 8'hA1);
    chk("R1", 12'h018, 8'h80);  // the unclaimed ready write left no trace (R3)
    chk_burst("R1", 16'd0);
    wr(12'h000, 8'h20);
    chk("R2", 12'h000, 8'h81);
    wr(12'h000, 8'h08);
    chk("R2", 12'h000, 8'hA1);
  endtask

  task automatic t_command;
    wr(12'h018, 8'h40);
    chk("R5", 12'h018, 8'hC0);
    chk_burst("R5", 16'(DEPTH));
    load_cmd(3);
    chk("R6", 12'h018, 8'h88);
    chk_burst("R7", 16'(DEPTH - 3));
    load_cmd(8);                // rewrites from index 3 onward? no: continue
  endtask

  task automatic t_full_command;
    wr(12'h018, 8'h40);
    wr(12'h024, cmd[0]); wr(12'h024, cmd[1]);
    wr(12'h024, cmd[2]); wr(12'h024, cmd[3]); wr(12'h024, cmd[4]); wr(12'h024, cmd[5]);
    wr(12'h024, cmd[6]); wr(12'h024, cmd[7]);
    chk("R6", 12'h018, 8'h88);
    chk_burst("R7", 16'(DEPTH - 8));
    wr(12'h018, 8'h20);         // go before complete
    repeat (EXEC_CYCLES + 4) @(negedge clk);
    chk("R8", 12'h018, 8'h88);
    for (int i = 8; i < 12; i++) wr(12'h024, cmd[i]);
    chk("R6", 12'h018, 8'h80);
    chk_burst("R7", 16'd0);
    wr(12'h024, 8'h77);         // extra byte dropped
    chk("R6", 12'h018, 8'h80);
  endtask

  task automatic t_exec_and_drain;
    logic [7:0] exp;
    wr(12'h018, 8'h20);
    repeat (EXEC_CYCLES - 1) @(negedge clk);
    chk("R9", 12'h018, 8'h80);
    chk("R9", 12'h018, 8'h90);
    chk_burst("R9", 16'(RSP_LEN));
    for (int i = 0; i < RSP_LEN; i++) begin
      case (i)
        1: exp = 8'hC4;
        5: exp = 8'(RSP_LEN);
        10, 11: exp = cmd[i];
        default: exp = 8'h00;
      endcase
      chk("R10", 12'h024, exp);
      if (i == 3) chk_burst("R10", 16'(RSP_LEN - 4));
    end
    chk("R10", 12'h018, 8'h80);
    chk_burst("R10", 16'd0);
    chk("R10", 12'h024, 8'hFF);
  endtask

  task automatic t_retry_and_abort;
    wr(12'h018, 8'h02);
    chk("R11", 12'h018, 8'h90);
    chk("R11", 12'h024, 8'h00);
    chk("R11", 12'h024, 8'hC4);
    chk_burst("R11", 16'(RSP_LEN - 2));
    wr(12'h018, 8'h40);
    chk("R12", 12'h018, 8'hC0);
    chk("R12", 12'h024, 8'hFF);
    chk_burst("R12", 16'(DEPTH));
  endtask

  task automatic t_overflow;
    wr(12'h018, 8'h40);
    wr(12'h024, 8'h00); wr(12'h024, 8'hC1);
    wr(12'h024, 8'h00); wr(12'h024, 8'h01); wr(12'h024, 8'h00); wr(12'h024, 8'h00);
    for (int i = 6; i < DEPTH; i++) wr(12'h024, 8'(i));
    chk_burst("R7", 16'd0);
    chk("R7", 12'h018, 8'h88);
    wr(12'h024, 8'h55);
    chk_burst("R7", 16'd0);
    wr(12'h018, 8'h20);         // go on incomplete command
    repeat (EXEC_CYCLES + 4) @(negedge clk);
    chk("R8", 12'h018, 8'h88);
  endtask

  task automatic t_inactive_write;
    wr(12'h000, 8'h20);
    wr(12'h018, 8'h40);         // ignored while released
    wr(12'h000, 8'h02);
    chk("R3", 12'h018, 8'h88);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) cmd[i] = 8'(8'h30 + i);
    cmd[0] = 8'h00; cmd[1] = 8'hC1;
    cmd[2] = 8'h00; cmd[3] = 8'h00; cmd[4] = 8'h00; cmd[5] = 8'h0C;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_and_idle();
    t_claim();
    t_full_command();
    t_exec_and_drain();
    t_retry_and_abort();
    t_overflow();
    t_inactive_write();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1..: actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule